// File: doc/BRIEF.md
# Dual Mode-Configurable Timer/Counter

This block holds two 16-bit counting channels. Each channel is built from a low byte and a high byte. One shared configuration byte and one shared control byte govern both channels, and a small byte-wide register port reaches all of them. Each channel advances on one of two sources: the machine-cycle strobe `tick_en`, or falling edges on its own external count pin, which is sampled on that strobe. A run bit enables the channel. Each channel can also be made to depend on a level input, its gate pin.

Every channel has four counting shapes. The first is a 13-bit count, made of a 5-bit prescaler in the low byte and the full high byte. The second is a plain 16-bit count. The third is an 8-bit count in the low byte that reloads from the high byte. The fourth is a split arrangement. In it, channel 0 becomes two independent 8-bit counters and channel 1 halts. When a channel wraps, it raises a sticky overflow flag. That flag is cleared either by the matching acknowledge input or by a software write to the control byte.

Top module: `twin_tick_counter`

## Requirements
- R1: After a synchronous reset, all counter bytes, the configuration byte, the run bits, both overflow flags and `rdata` are zero.
- R2: Register addresses are 0 control, 1 configuration, 2 channel 0 low, 3 channel 0 high, 4 channel 1 low, 5 channel 1 high, and 6 and 7 read as zero. The control byte holds channel 1 flag at bit 7, channel 1 run at bit 6, channel 0 flag at bit 5 and channel 0 run at bit 4, and bits 3..0 read as zero. In the configuration byte, bits 7..4 belong to channel 1 and bits 3..0 to channel 0. Within each nibble the fields are gate enable (bit 3), external source (bit 2) and shape (bits 1..0). `rdata` shows the addressed register as it stood before the clock edge that captures it.
- R3: Shape 01 counts `{high, low}` as a 16-bit value. Stepping from 0xFFFF wraps it to 0x0000 and raises the channel's flag.
- R4: Shape 10 increments only the low byte. A step taken while the low byte is 0xFF loads the low byte from the high byte and raises the channel's flag.
- R5: A channel steps only in a cycle where its run bit is 1 and either its gate enable is 0 or its gate pin is 1. In internal mode that cycle must also have `tick_en` high. In external mode it must contain a counted edge.
- R6: Shape 00 counts `{high, low[4:0]}` as a 13-bit value and leaves `low[7:5]` untouched. Stepping from all ones wraps it to zero and raises the flag.
- R7: When channel 0 uses shape 11, its low byte is an 8-bit counter under channel 0's controls and raises flag 0 on wrap. Its high byte steps on every `tick_en` cycle while run bit 1 is set, and raises flag 1 on wrap. Channel 1's own wraps then leave flag 1 alone. A channel 1 set to shape 11 never steps.
- R8: A write to the control byte loads both flags from bits 7 and 5. A hardware flag set in the same cycle wins over a written 0.
- R9: `irq_ack[i]` clears flag i, unless that same cycle sets the flag or writes the control byte.
- R10: In external mode, the count pin is sampled on every `tick_en` cycle. A step happens on the `tick_en` cycle after the one whose sample is the first low following a high sample.
- R11: A write to a counter byte replaces that byte in the same cycle, and any step for that byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Machine-cycle strobe |
| cnt_pin | input | 2 | External count inputs, bit i for channel i |
| gate_pin | input | 2 | Gate level inputs, bit i for channel i |
| irq_ack | input | 2 | Flag clear strobes from the interrupt side |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ovf_flag | output | 2 | Overflow flags, bit i for channel i |

## Verification
The properties treat `cnt_pin` and `gate_pin` as already synchronous to `clk`. They also treat a register write as touching only the addressed byte in that cycle. The stimulus changes every input just after the falling clock edge, so each value is stable across the edge that captures it. The acknowledge-clearing property holds only in cycles without `tick_en`, because only then can no overflow compete with it. Random phases keep the acknowledges and writes sparse, so that flags and counts live long enough to be observed.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
  typedef enum logic [1:0] {
    MD_PRESCALED = 2'b00,
    MD_CASCADE   = 2'b01,
    MD_RELOAD    = 2'b10,
    MD_SPLIT     = 2'b11
  } ttc_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext;
    ttc_mode_e mode;
  } ttc_cfg_t;

  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned NUM_CH  = 2;
  localparam int unsigned CFG_W   = 4;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LO0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_HI0  = 3'd3;
  localparam logic [ADDR_W-1:0] A_LO1  = 3'd4;
  localparam logic [ADDR_W-1:0] A_HI1  = 3'd5;
  localparam int unsigned RUN_BIT0  = 4;
  localparam int unsigned FLAG_BIT0 = 5;
endpackage

// File: rtl/ttc_pin_sampler.sv
module ttc_pin_sampler (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic now_q;
  logic old_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q <= 1'b0;
      old_q <= 1'b0;
    end else if (tick) begin
      now_q <= pin;
      old_q <= now_q;
    end
  end

  assign fall = tick & old_q & ~now_q;
endmodule

// File: rtl/ttc_channel.sv
module ttc_channel
  import ttc_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  ttc_mode_e         mode,
  input  logic              inc_main,
  input  logic              inc_aux,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              ovf_main,
  output logic              ovf_aux
);
  localparam int unsigned PW = BYTE_W + PRE_W;
  localparam int unsigned CW = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] ONE_B = BYTE_W'(1);

  logic [BYTE_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic [PW-1:0]     pre_sum;
  logic [CW-1:0]     cas_sum;

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    ovf_main = 1'b0;
    ovf_aux  = 1'b0;
    pre_sum  = {hi_q, lo_q[PRE_W-1:0]} + PW'(1);
    cas_sum  = {hi_q, lo_q} + CW'(1);
    if (inc_main) begin
      unique case (mode)
        MD_PRESCALED: begin
          lo_d[PRE_W-1:0] = pre_sum[PRE_W-1:0];
          hi_d            = pre_sum[PW-1:PRE_W];
          ovf_main        = &{hi_q, lo_q[PRE_W-1:0]};
        end
        MD_CASCADE: begin
          {hi_d, lo_d} = cas_sum;
          ovf_main     = &{hi_q, lo_q};
        end
        MD_RELOAD: begin
          if (&lo_q) begin
            lo_d     = hi_q;
            ovf_main = 1'b1;
          end else begin
            lo_d = lo_q + ONE_B;
          end
        end
        default: begin
          lo_d     = lo_q + ONE_B;
          ovf_main = &lo_q;
        end
      endcase
    end
    if (inc_aux && (mode == MD_SPLIT)) begin
      hi_d    = hi_q + ONE_B;
      ovf_aux = &hi_q;
    end
    if (wr_lo) lo_d = wdata;
    if (wr_hi) hi_d = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo = lo_q;
  assign hi = hi_q;
endmodule

// File: rtl/twin_tick_counter.sv
module twin_tick_counter
  import ttc_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [1:0]        cnt_pin,
  input  logic [1:0]        gate_pin,
  input  logic [1:0]        irq_ack,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [1:0]        ovf_flag
);
  localparam int unsigned MODE_W = NUM_CH * CFG_W;

  logic [MODE_W-1:0] mode_q;
  logic [NUM_CH-1:0] run_q, flag_q, flag_set;
  logic [NUM_CH-1:0] fall, open, src, inc_main, inc_aux, ovf_main, ovf_aux;
  logic [NUM_CH-1:0] wr_lo, wr_hi;
  logic [BYTE_W-1:0] cnt_lo [NUM_CH];
  logic [BYTE_W-1:0] cnt_hi [NUM_CH];
  ttc_cfg_t          cfg    [NUM_CH];
  logic              wr_ctrl, split0;
  logic [BYTE_W-1:0] rd_d;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign split0  = (cfg[0].mode == MD_SPLIT);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign cfg[i]  = ttc_cfg_t'(mode_q[CFG_W*i +: CFG_W]);
    assign open[i] = run_q[i] & (~cfg[i].gate | gate_pin[i]);
    assign src[i]  = cfg[i].ext ? fall[i] : tick_en;
    assign wr_lo[i] = wr_en && (addr == A_LO0 + ADDR_W'(2*i));
    assign wr_hi[i] = wr_en && (addr == A_HI0 + ADDR_W'(2*i));

    ttc_pin_sampler u_smp (
      .clk  (clk),
      .rst  (rst),
      .tick (tick_en),
      .pin  (cnt_pin[i]),
      .fall (fall[i])
    );

    ttc_channel #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .mode     (cfg[i].mode),
      .inc_main (inc_main[i]),
      .inc_aux  (inc_aux[i]),
      .wr_lo    (wr_lo[i]),
      .wr_hi    (wr_hi[i]),
      .wdata    (wdata),
      .lo       (cnt_lo[i]),
      .hi       (cnt_hi[i]),
      .ovf_main (ovf_main[i]),
      .ovf_aux  (ovf_aux[i])
    );
  end

  // Channel 1 halts in split shape; channel 0 high byte borrows run bit 1.
  assign inc_main[0] = open[0] & src[0];
  assign inc_main[1] = open[1] & src[1] & (cfg[1].mode != MD_SPLIT);
  assign inc_aux[0]  = tick_en & run_q[1];
  assign inc_aux[1]  = 1'b0;

  assign flag_set[0] = ovf_main[0];
  assign flag_set[1] = split0 ? ovf_aux[0] : ovf_main[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en && (addr == A_CFG)) mode_q <= wdata[MODE_W-1:0];
      for (int i = 0; i < NUM_CH; i++) begin
        if (wr_ctrl) run_q[i] <= wdata[RUN_BIT0 + 2*i];
        if (flag_set[i])      flag_q[i] <= 1'b1;
        else if (wr_ctrl)     flag_q[i] <= wdata[FLAG_BIT0 + 2*i];
        else if (irq_ack[i])  flag_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_d = '0;
    unique case (addr)
      A_CTRL: begin
        for (int i = 0; i < NUM_CH; i++) begin
          rd_d[RUN_BIT0 + 2*i]  = run_q[i];
          rd_d[FLAG_BIT0 + 2*i] = flag_q[i];
        end
      end
      A_CFG:   rd_d[MODE_W-1:0] = mode_q;
      A_LO0:   rd_d = cnt_lo[0];
      A_HI0:   rd_d = cnt_hi[0];
      A_LO1:   rd_d = cnt_lo[1];
      A_HI1:   rd_d = cnt_hi[1];
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end

  assign ovf_flag = flag_q;
endmodule

// File: rtl/ttc_checker.sv
module ttc_checker #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              wr_en,
  input logic [2:0]        addr,
  input logic [1:0]        irq_ack,
  input logic [1:0]        ovf_flag,
  input logic [7:0]        mode_q,
  input logic [1:0]        run_q,
  input logic [BYTE_W-1:0] lo0,
  input logic [BYTE_W-1:0] hi0,
  input logic [BYTE_W-1:0] lo1,
  input logic [BYTE_W-1:0] hi1
);
  logic wr_ctl, wr_c0, wr_c1;
  assign wr_ctl = wr_en && (addr == 3'd0);
  assign wr_c0  = wr_en && ((addr == 3'd2) || (addr == 3'd3));
  assign wr_c1  = wr_en && ((addr == 3'd4) || (addr == 3'd5));

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag[0] && !irq_ack[0] && !wr_ctl) |=> ovf_flag[0]);

  p_ack_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_ack[1] && !tick_en && !wr_ctl) |=> !ovf_flag[1]);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !wr_en) |=>
      ($stable(lo0) && $stable(hi0) && $stable(lo1) && $stable(hi1)));

  p_run_off_r5: assert property (@(posedge clk) disable iff (rst)
    (!run_q[0] && !wr_c0 && (mode_q[1:0] != 2'b11)) |=> ($stable(lo0) && $stable(hi0)));

  p_ch1_halt_r7: assert property (@(posedge clk) disable iff (rst)
    ((mode_q[5:4] == 2'b11) && !wr_c1) |=> ($stable(lo1) && $stable(hi1)));

  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    ((mode_q[3:0] == 4'b0010) && run_q[0] && tick_en && (&lo0) && !wr_c0)
      |=> (lo0 == $past(hi0)));
endmodule

bind twin_tick_counter ttc_checker #(.BYTE_W(BYTE_W)) u_ttc_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_en  (tick_en),
  .wr_en    (wr_en),
  .addr     (addr),
  .irq_ack  (irq_ack),
  .ovf_flag (ovf_flag),
  .mode_q   (mode_q),
  .run_q    (run_q),
  .lo0      (cnt_lo[0]),
  .hi0      (cnt_hi[0]),
  .lo1      (cnt_lo[1]),
  .hi1      (cnt_hi[1])
);

// File: tb/twin_tick_counter_tb.sv
module twin_tick_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] cnt_pin = 2'b11;
  logic [1:0] gate_pin = 2'b11;
  logic [1:0] irq_ack = 2'b00;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [1:0] ovf_flag;

  always #2 clk = ~clk;

  twin_tick_counter dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .irq_ack(irq_ack), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ovf_flag(ovf_flag)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string req = "R1";
  bit    done = 1'b0;

  logic [7:0] m_lo [2];
  logic [7:0] m_hi [2];
  logic [7:0] m_mode;
  logic [1:0] m_run, m_flag, m_s1, m_s2;

  function automatic logic [7:0] peek(input logic [2:0] a);
    case (a)
      3'd0: return {m_flag[1], m_run[1], m_flag[0], m_run[0], 4'b0000};
      3'd1: return m_mode;
      3'd2: return m_lo[0];
      3'd3: return m_hi[0];
      3'd4: return m_lo[1];
      3'd5: return m_hi[1];
      default: return 8'h00;
    endcase
  endfunction

  task automatic cycle(input logic t, input logic [1:0] cp, input logic [1:0] gp,
                       input logic [1:0] ack, input logic we, input logic [2:0] a,
                       input logic [7:0] wd);
    logic [7:0]  exp_rd;
    logic [1:0]  ev, inc, ovf, setf;
    logic        aux_inc, aux_ovf;
    logic [1:0]  md [2];
    logic [12:0] v13;
    logic [15:0] v16;
    tick_en = t; cnt_pin = cp; gate_pin = gp; irq_ack = ack;
    wr_en = we; addr = a; wdata = wd;
    exp_rd = peek(a);
    for (int i = 0; i < 2; i++) begin
      md[i]  = m_mode[4*i +: 2];
      ev[i]  = t & m_s2[i] & ~m_s1[i];
      inc[i] = m_run[i] & (~m_mode[4*i+3] | gp[i]) & (m_mode[4*i+2] ? ev[i] : t);
    end
    if (md[1] == 2'b11) inc[1] = 1'b0;
    aux_inc = t & m_run[1] & (md[0] == 2'b11);
    ovf = 2'b00; aux_ovf = 1'b0;
    for (int i = 0; i < 2; i++) begin
      if (inc[i]) begin
        case (md[i])
          2'b00: begin
            v13 = {m_hi[i], m_lo[i][4:0]};
            ovf[i] = (v13 == 13'h1FFF);
            v13 = v13 + 13'd1;
            m_hi[i] = v13[12:5]; m_lo[i][4:0] = v13[4:0];
          end
          2'b01: begin
            v16 = {m_hi[i], m_lo[i]};
            ovf[i] = (v16 == 16'hFFFF);
            v16 = v16 + 16'd1;
            m_hi[i] = v16[15:8]; m_lo[i] = v16[7:0];
          end
          2'b10: begin
            if (m_lo[i] == 8'hFF) begin m_lo[i] = m_hi[i]; ovf[i] = 1'b1; end
            else m_lo[i] = m_lo[i] + 8'd1;
          end
          default: begin
            ovf[i] = (m_lo[i] == 8'hFF);
            m_lo[i] = m_lo[i] + 8'd1;
          end
        endcase
      end
    end
    if (aux_inc) begin
      aux_ovf = (m_hi[0] == 8'hFF);
      m_hi[0] = m_hi[0] + 8'd1;
    end
    if (t) begin m_s2 = m_s1; m_s1 = cp; end
    if (we && a == 3'd2) m_lo[0] = wd;
    if (we && a == 3'd3) m_hi[0] = wd;
    if (we && a == 3'd4) m_lo[1] = wd;
    if (we && a == 3'd5) m_hi[1] = wd;
    setf[0] = ovf[0];
    setf[1] = (md[0] == 2'b11) ? aux_ovf : ovf[1];
    for (int i = 0; i < 2; i++) begin
      if (setf[i])              m_flag[i] = 1'b1;
      else if (we && a == 3'd0) m_flag[i] = wd[5 + 2*i];
      else if (ack[i])          m_flag[i] = 1'b0;
      if (we && a == 3'd0) m_run[i] = wd[4 + 2*i];
    end
    if (we && a == 3'd1) m_mode = wd;
    @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (rdata !== exp_rd) begin
      n_bad++;
      $display("FAIL %s rdata addr=%0d actual=%02h expected=%02h", req, a, rdata, exp_rd);
    end
    n_chk++;
    if (ovf_flag !== m_flag) begin
      n_bad++;
      $display("FAIL %s ovf_flag actual=%b expected=%b", req, ovf_flag, m_flag);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cycle(1'b0, 2'b11, 2'b11, 2'b00, 1'b1, a, d);
  endtask

  task automatic rd(input logic [2:0] a);
    cycle(1'b0, 2'b11, 2'b11, 2'b00, 1'b0, a, 8'h00);
  endtask

  task automatic ticks(input int n, input logic [2:0] a);
    for (int k = 0; k < n; k++) cycle(1'b1, 2'b11, 2'b11, 2'b00, 1'b0, a, 8'h00);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog %s actual=hung expected=finished", req);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd91357));
    m_lo[0] = 0; m_lo[1] = 0; m_hi[0] = 0; m_hi[1] = 0;
    m_mode = 0; m_run = 0; m_flag = 0; m_s1 = 0; m_s2 = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    req = "R1";  // reset state of every register
    for (int a = 0; a < 8; a++) rd(3'(a));

    req = "R2";  // register map and registered read
    wr(3'd1, 8'hA5); rd(3'd1); wr(3'd4, 8'h3C); wr(3'd5, 8'hC3);
    rd(3'd4); rd(3'd5); rd(3'd6); rd(3'd7); wr(3'd1, 8'h00); rd(3'd0);

    req = "R3";  // 16-bit cascade wrap
    wr(3'd1, 8'h01); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd0, 8'h10);
    ticks(3, 3'd3); rd(3'd2); rd(3'd0);

    req = "R9";  // acknowledge clears flag 0
    cycle(1'b0, 2'b11, 2'b11, 2'b01, 1'b0, 3'd0, 8'h00); rd(3'd0);

    req = "R6";  // 13-bit prescaled wrap, upper low bits kept
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'hFD); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h10); ticks(4, 3'd2); rd(3'd3); rd(3'd2);

    req = "R4";  // 8-bit reload on both channels
    wr(3'd0, 8'h00); wr(3'd1, 8'h22); wr(3'd3, 8'hF0); wr(3'd2, 8'hFD);
    wr(3'd5, 8'h80); wr(3'd4, 8'hFE); wr(3'd0, 8'h50);
    ticks(6, 3'd2); rd(3'd4); rd(3'd0);

    req = "R5";  // gating by run bit and gate pin
    wr(3'd0, 8'h00); wr(3'd1, 8'h09); wr(3'd2, 8'h10); wr(3'd3, 8'h00);
    ticks(3, 3'd2);
    wr(3'd0, 8'h10);
    for (int k = 0; k < 4; k++) cycle(1'b1, 2'b11, 2'b10, 2'b00, 1'b0, 3'd2, 8'h00);
    ticks(3, 3'd2);
    cycle(1'b0, 2'b11, 2'b11, 2'b00, 1'b0, 3'd2, 8'h00);

    req = "R10";  // external falling edges
    wr(3'd1, 8'h05); wr(3'd2, 8'h00);
    for (int k = 0; k < 16; k++)
      cycle(k % 3 != 2, {1'b1, logic'((k / 2) % 2)}, 2'b11, 2'b00, 1'b0, 3'd2, 8'h00);
    rd(3'd2);

    req = "R7";  // split shape
    wr(3'd0, 8'h00); wr(3'd1, 8'h33); wr(3'd4, 8'h44); wr(3'd5, 8'h55);
    wr(3'd3, 8'hFE); wr(3'd2, 8'hFE); wr(3'd0, 8'h50);
    ticks(4, 3'd3); rd(3'd4); rd(3'd5); rd(3'd0);
    wr(3'd0, 8'h40); wr(3'd1, 8'h13); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    ticks(3, 3'd4); rd(3'd0);

    req = "R8";  // hardware set beats written zero
    wr(3'd0, 8'h00); wr(3'd1, 8'h01); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h10);
    cycle(1'b1, 2'b11, 2'b11, 2'b00, 1'b1, 3'd0, 8'h10); rd(3'd0);
    wr(3'd0, 8'hA0); rd(3'd0); wr(3'd0, 8'h10); rd(3'd0);

    req = "R11";  // write overrides a step
    wr(3'd2, 8'h20);
    cycle(1'b1, 2'b11, 2'b11, 2'b00, 1'b1, 3'd2, 8'h77); rd(3'd2);

    req = "R2";  // randomized mix
    for (int k = 0; k < 4000; k++) begin
      logic       t, we;
      logic [1:0] cp, gp, ack;
      t   = logic'($urandom % 2);
      cp  = 2'($urandom);
      gp  = ($urandom % 4 != 0) ? 2'b11 : 2'($urandom);
      ack = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      we  = ($urandom % 8 == 0);
      cycle(t, cp, gp, ack, we, 3'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule